// File: doc/BRIEF.md
# Byte-Wide Serial Port Register Front End

This block is the host-facing register file of a legacy-style serial port. A processor reaches it through eight byte-wide addresses, using a read strobe and a write strobe. Line timing is not part of this block. Bytes for the wire leave through a valid/ready stream toward a transmitter. Bytes from the wire arrive through a valid-only stream from a receiver and are held in an internal queue until the host reads them.

The block contains the usual control state: interrupt enables, line control, modem control, a scratch byte and a 16-bit rate divisor. The divisor is reached by setting the latch-access bit in line control. A loopback mode sends transmitted bytes straight into the receive queue. A single interrupt request line reflects a pending-event code, and reading that code acknowledges it. Read data is combinational from the current state. Read side effects and all writes take effect at the clock edge where the strobe is high.

Top module: `serial_regs`

## Requirements
- R1: After reset, the following values read back: line control 0x03, line status 0x60, interrupt identification 0x01, and interrupt enable, modem control, modem status and scratch all 0x00. `irq` and `tx_valid` are low.
- R2: Scratch (offset 7) and line control (offset 3) store all eight bits written. Modem control (offset 4) stores all eight bits, and its bit 4 selects loopback.
- R3: Interrupt enable (offset 1) keeps only bits 3:0 of a write: bit 0 enables received data, bit 1 enables transmit empty. Bits 7:4 read 0.
- R4: While line control bit 7 is 1, offset 0 reads and writes divisor bits 7:0 and offset 1 reads and writes divisor bits 15:8. Each write changes only its own byte, and nothing is transmitted. While bit 7 is 0, those offsets return to the data and enable registers.
- R5: Interrupt identification (offset 2) reads 0x01 when nothing is pending, 0x04 for received data and 0x02 for transmit empty. Bits 7:4 always read 0. A read returns the current code, and from the next cycle the code is back to 0x01. `irq` is high exactly while the code is not 0x01.
- R6: Outside loopback, a write to offset 0 loads the byte into `tx_data` and raises `tx_valid` on the next cycle. The byte is held until `tx_ready` accepts it. While the byte is held, line status bits 5 and 6 read 0. If enable bit 1 is set, the code becomes 0x02.
- R7: In loopback, a write to offset 0 appends the byte to the receive queue, and `tx_valid` stays low. The `rx_valid` input is ignored while loopback is on.
- R8: Line status bit 0 is 1 while the receive queue holds a byte. A read of offset 0 pops the oldest byte in first-in first-out order. A read of an empty queue returns 0xFF.
- R9: A byte accepted from `rx_valid`/`rx_data`, or appended in loopback, sets the code to 0x04 if enable bit 0 is set. With that bit clear, the code is left unchanged.
- R10: A byte that arrives while the queue already holds DEPTH bytes is dropped, and line status bit 1 (overrun) is set. A read of line status (offset 5) returns the overrun bit and then clears it.
- R11: Writes to offsets 2, 5 and 6 change no readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe (applies read side effects) |
| rdata | output | 8 | Read data for `addr` |
| tx_data | output | 8 | Outgoing byte |
| tx_valid | output | 1 | Outgoing byte is held |
| tx_ready | input | 1 | Transmitter accepts the byte |
| rx_data | input | 8 | Incoming byte |
| rx_valid | input | 1 | Incoming byte present this cycle |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with DEPTH=4. With that depth, a full queue and an overrun are reached after five incoming bytes, so the drop rule and the overrun bit's read-clear can be checked directly. The scratch and interrupt-enable registers are swept over all 256 write values, with the expected readback computed as the value itself or as the value masked to its low nibble. The divisor aliasing, loopback ordering, empty-queue read and transmit back-pressure are each driven at this same small configuration.

// File: rtl/serial_regs.sv
module serial_regs #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] addr,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic       rd_en,
  output logic [7:0] rdata,
  output logic [7:0] tx_data,
  output logic       tx_valid,
  input  logic       tx_ready,
  input  logic [7:0] rx_data,
  input  logic       rx_valid,
  output logic       irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IX  = AW'(DEPTH - 1);

  logic [7:0]    q [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic [3:0]    ier, iid;
  logic [7:0]    lcr, mcr, scr;
  logic [15:0]   div;
  logic          ovr;

  wire dlab     = lcr[7];
  wire loop     = mcr[4];
  wire empty    = (cnt == '0);
  wire full     = (cnt == FULL_CNT);
  wire wr_thr   = wr_en && addr == 3'd0 && !dlab;
  wire rd_rbr   = rd_en && addr == 3'd0 && !dlab;
  wire tx_load  = wr_thr && !loop;
  wire lb_push  = wr_thr && loop;
  wire rx_take  = rx_valid && !loop;
  wire push_req = lb_push || rx_take;
  wire [7:0] push_data = lb_push ? wdata : rx_data;
  wire pop      = rd_rbr && !empty;
  wire push     = push_req && (!full || pop);
  wire drop     = push_req && full && !pop;
  wire [7:0] lsr = {1'b0, !tx_valid, !tx_valid, 3'b000, ovr, !empty};

  assign irq = ~iid[0];

  always_comb begin
    rdata = 8'h00;
    case (addr)
      3'd0: rdata = dlab ? div[7:0] : (empty ? 8'hFF : q[rp]);
      3'd1: rdata = dlab ? div[15:8] : {4'h0, ier};
      3'd2: rdata = {4'h0, iid};
      3'd3: rdata = lcr;
      3'd4: rdata = mcr;
      3'd5: rdata = lsr;
      3'd6: rdata = 8'h00;
      3'd7: rdata = scr;
      default: rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (push) q[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
      ier <= '0; iid <= 4'b0001; lcr <= 8'h03; mcr <= '0; scr <= '0;
      div <= '0; ovr <= 1'b0; tx_valid <= 1'b0; tx_data <= '0;
    end else begin
      if (push) wp <= (wp == LAST_IX) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == LAST_IX) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);

      if (rd_en && addr == 3'd5) ovr <= 1'b0;
      if (drop) ovr <= 1'b1;

      if (wr_en) begin
        case (addr)
          3'd0: if (dlab) div[7:0] <= wdata;
          3'd1: if (dlab) div[15:8] <= wdata; else ier <= wdata[3:0];
          3'd3: lcr <= wdata;
          3'd4: mcr <= wdata;
          3'd7: scr <= wdata;
          default: ;
        endcase
      end

      if (tx_valid && tx_ready) tx_valid <= 1'b0;
      if (tx_load) begin
        tx_data  <= wdata;
        tx_valid <= 1'b1;
      end

      if (rd_en && addr == 3'd2) iid <= 4'b0001;
      if (tx_load && ier[1]) iid <= 4'b0010;
      if (push_req && ier[0]) iid <= 4'b0100;
    end
  end

  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n) cnt <= FULL_CNT);
  a_r10_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !loop && full && !rd_rbr) |=> lsr[1]);
  a_r8_empty_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr[0] == 1'b0 && addr == 3'd0 && !dlab) |-> rdata == 8'hFF);
  a_r5_read_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd2 && !wr_en && !rx_valid) |=> !irq);
  a_r7_loop_no_tx: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> !$past(loop));
  a_r4_div_low_only: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0 && dlab) |=> $stable(div[15:8]) && $stable(tx_valid));
endmodule

// File: tb/serial_regs_test.sv
module serial_regs_test;
  localparam int DEPTH = 4;
  logic clk = 0, rst_n = 0;
  logic [2:0] addr = 0;
  logic wr_en = 0, rd_en = 0, tx_ready = 1, rx_valid = 0;
  logic [7:0] wdata = 0, rx_data = 0;
  logic [7:0] rdata, tx_data;
  logic tx_valid, irq;
  int total = 0, bad = 0, tx_seen = 0;
  logic [7:0] tx_last = 0;

  serial_regs #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid), .irq(irq));

  always #2.5 clk = ~clk;

  always @(negedge clk) if (tx_valid && tx_ready) begin
    tx_seen++;
    tx_last = tx_data;
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd_en = 1; #1 v = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic rxb(logic [7:0] d);
    @(negedge clk); rx_data = d; rx_valid = 1;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #500000;
    total++; bad++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values
    rd(3'd3, v); chk("R1 lcr", v, 8'h03);
    rd(3'd5, v); chk("R1 lsr", v, 8'h60);
    rd(3'd2, v); chk("R1 iid", v, 8'h01);
    rd(3'd1, v); chk("R1 ier", v, 8'h00);
    rd(3'd4, v); chk("R1 mcr", v, 8'h00);
    rd(3'd6, v); chk("R1 msr", v, 8'h00);
    rd(3'd7, v); chk("R1 scr", v, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 tx_valid", {7'b0, tx_valid}, 8'h00);

    // R2 scratch sweep, R3 enable sweep
    for (int i = 0; i < 256; i++) begin
      wr(3'd7, 8'(i)); rd(3'd7, v); chk("R2 scr", v, 8'(i));
      wr(3'd1, 8'(i)); rd(3'd1, v); chk("R3 ier", v, 8'(i) & 8'h0F);
    end
    wr(3'd1, 8'h00);
    wr(3'd3, 8'h1B); rd(3'd3, v); chk("R2 lcr", v, 8'h1B);
    wr(3'd4, 8'hA3); rd(3'd4, v); chk("R2 mcr", v, 8'hA3);
    wr(3'd4, 8'h00);

    // R4 divisor latch
    wr(3'd1, 8'h05);
    wr(3'd3, 8'h83);
    n = tx_seen;
    wr(3'd0, 8'h34); wr(3'd1, 8'h12);
    rd(3'd0, v); chk("R4 div lo", v, 8'h34);
    rd(3'd1, v); chk("R4 div hi", v, 8'h12);
    wr(3'd0, 8'h77);
    rd(3'd0, v); chk("R4 div lo rewrite", v, 8'h77);
    rd(3'd1, v); chk("R4 div hi kept", v, 8'h12);
    chk("R4 no tx", 8'(tx_seen - n), 8'h00);
    wr(3'd3, 8'h03);
    rd(3'd1, v); chk("R4 ier back", v, 8'h05);
    rd(3'd0, v); chk("R4 rbr back", v, 8'hFF);
    wr(3'd1, 8'h00);

    // R6 transmit path, R5 acknowledge
    wr(3'd1, 8'h02);
    n = tx_seen;
    wr(3'd0, 8'hA5);
    @(negedge clk);
    chk("R6 tx count", 8'(tx_seen - n), 8'h01);
    chk("R6 tx byte", tx_last, 8'hA5);
    chk("R5 irq high", {7'b0, irq}, 8'h01);
    rd(3'd2, v); chk("R5 iid tx", v, 8'h02);
    chk("R5 irq low", {7'b0, irq}, 8'h00);
    rd(3'd2, v); chk("R5 iid cleared", v, 8'h01);
    tx_ready = 0;
    wr(3'd0, 8'h5A);
    rd(3'd5, v); chk("R6 lsr busy", v, 8'h00);
    chk("R6 held", tx_data, 8'h5A);
    tx_ready = 1;
    @(negedge clk); @(negedge clk);
    rd(3'd5, v); chk("R6 lsr idle", v, 8'h60);
    chk("R6 last byte", tx_last, 8'h5A);
    rd(3'd2, v);

    // R7 loopback, R8 ordering and empty read, R9 interrupt
    wr(3'd1, 8'h01); wr(3'd4, 8'h10);
    n = tx_seen;
    wr(3'd0, 8'h11); wr(3'd0, 8'h22);
    rxb(8'hEE);
    wr(3'd0, 8'h33);
    chk("R7 no tx", 8'(tx_seen - n), 8'h00);
    chk("R9 irq", {7'b0, irq}, 8'h01);
    rd(3'd2, v); chk("R9 iid rx", v, 8'h04);
    rd(3'd5, v); chk("R8 dr set", v, 8'h61);
    rd(3'd0, v); chk("R8 byte0", v, 8'h11);
    rd(3'd0, v); chk("R8 byte1", v, 8'h22);
    rd(3'd0, v); chk("R7 rx ignored", v, 8'h33);
    rd(3'd5, v); chk("R8 dr clear", v, 8'h60);
    rd(3'd0, v); chk("R8 empty ff", v, 8'hFF);
    wr(3'd4, 8'h00);

    // R10 overrun, R9 gating
    wr(3'd1, 8'h00);
    for (int i = 0; i <= DEPTH; i++) rxb(8'(i * 7 + 1));
    rd(3'd2, v); chk("R9 no iid when off", v, 8'h01);
    rd(3'd5, v); chk("R10 ovr set", v, 8'h63);
    rd(3'd5, v); chk("R10 ovr cleared", v, 8'h61);
    for (int i = 0; i < DEPTH; i++) begin
      rd(3'd0, v); chk("R10 kept byte", v, 8'(i * 7 + 1));
    end
    rd(3'd0, v); chk("R10 dropped", v, 8'hFF);
    wr(3'd1, 8'h01);
    rxb(8'h9C);
    chk("R9 irq rx", {7'b0, irq}, 8'h01);
    rd(3'd2, v); chk("R9 iid stream", v, 8'h04);
    rd(3'd0, v); chk("R8 stream byte", v, 8'h9C);

    // R11 ignored writes
    wr(3'd1, 8'h00);
    wr(3'd2, 8'hFF); wr(3'd5, 8'hFF); wr(3'd6, 8'hFF);
    rd(3'd2, v); chk("R11 iid", v, 8'h01);
    rd(3'd5, v); chk("R11 lsr", v, 8'h60);
    rd(3'd6, v); chk("R11 msr", v, 8'h00);
    rd(3'd3, v); chk("R11 lcr", v, 8'h03);
    chk("R11 irq", {7'b0, irq}, 8'h00);

    finish_run();
  end
endmodule